// File: doc/BRIEF.md
# Single-Access Classic Bus Master

This block turns one request at a time into a classic Wishbone bus access and hands the outcome back as a single result. A request arrives on a valid/ready port. It carries an address, a write word, a write-enable bit and a byte-lane select. The master raises cyc and stb and holds every bus field steady until the slave answers with ack, err or rty.

On ack or err the block samples the slave's read data, records whether an error was signalled, and closes the bus cycle. The outcome is held in a result register until the consumer takes it. On rty the block drops the bus for one cycle and then replays the identical access without any help from the requester.

Only one access is ever in flight. The request port stays not-ready from acceptance until the result has been consumed. A retried access therefore finishes before any other request can enter.

Top module: `wbc_single_master`

## Requirements
- R1: A request is accepted on a rising edge where req_valid and req_ready are both high. In the cycle after that edge, bus_cyc and bus_stb are high and bus_adr, bus_dat_w, bus_we and bus_sel equal the request's fields.
- R2: While bus_stb is high and none of bus_ack, bus_err or bus_rty is high, the next cycle keeps bus_stb high and leaves all address, data, write-enable and select outputs unchanged.
- R3: When bus_ack is high and bus_err is low during an open access, the next cycle shows bus_cyc and bus_stb low, res_valid high, res_data equal to the bus_dat_r value of the answering cycle, and res_err low. This holds for reads and writes alike.
- R4: When bus_rty is the only answer during an open access, bus_cyc and bus_stb are low for exactly one cycle. They are then high again, with the same address, data, write-enable and select.
- R5: While an access is outstanding, including the restart gap after a retry, req_ready is low. A request offered then is not taken, and it does not alter the bus fields.
- R6: When bus_err is high during an open access, the result carries res_err = 1 and the bus_dat_r value of that cycle. Err wins when ack is high at the same time.
- R7: A request that arrives after any number of idle cycles is handled exactly like one arriving right after the previous result was consumed.
- R8: A result stays valid with unchanged data and error flag until res_ready is high. Until then bus_cyc stays low and req_ready stays low. One cycle after the result is taken, req_ready is high.
- R9: A synchronous active-high reset, even in the middle of an access, leaves bus_cyc, bus_stb and res_valid low and req_ready high.
- R10: When bus_rty is high together with bus_ack or bus_err, the answer is treated as a completion, and no retry takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master can accept a request |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write word |
| req_we | input | 1 | Request is a write |
| req_sel | input | SEL_W | Request lane select |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Sampled read data |
| res_err | output | 1 | Access ended with an error |
| bus_cyc | output | 1 | Bus cycle open |
| bus_stb | output | 1 | Bus strobe |
| bus_adr | output | ADDR_W | Bus address |
| bus_dat_w | output | DATA_W | Bus write data |
| bus_we | output | 1 | Bus write enable |
| bus_sel | output | SEL_W | Bus lane select |
| bus_dat_r | input | DATA_W | Slave read data |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error |
| bus_rty | input | 1 | Slave retry request |

## Verification
The retry path is the main target. The bench checks that exactly one low-strobe cycle appears and that the replay carries the original fields. A new request is offered throughout the retry. A design that leaked it in would show the foreign address on the bus, and one that skipped the gap or stretched it would miss the sampled strobe values.

Simultaneous answers are also driven. With ack and err together, a design with the wrong priority would clear the error flag. With rty beside ack, a design that let rty win would reissue the access instead of returning a result.

A consumer that holds off for several cycles exposes a design that starts a new cycle or changes the result early. Slave wait states of varying length, and idle gaps of varying length between requests, catch any field that moves during an access. A reset in the middle of an access must close the bus at once.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUS  = 2'd1,
    PH_GAP  = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/wbc_req_hold.sv
module wbc_req_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_we,
  input  logic [SEL_W-1:0]  in_sel,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_we,
  output logic [SEL_W-1:0]  q_sel
);
  // Request fields stay registered for the whole access, including replays.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr  <= '0;
      q_wdata <= '0;
      q_we    <= 1'b0;
      q_sel   <= '0;
    end else if (load) begin
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
      q_we    <= in_we;
      q_sel   <= in_sel;
    end
  end
endmodule

// File: rtl/wbc_phase_ctrl.sv
module wbc_phase_ctrl
  import wbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic ans_ack,
  input  logic ans_err,
  input  logic ans_rty,
  input  logic res_taken,
  output logic req_ready,
  output logic accept,
  output logic finish,
  output logic on_bus
);
  phase_t phase, phase_nx;
  logic   retry;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign on_bus    = (phase == PH_BUS);
  // ack or err completes the access; rty only matters when alone
  assign finish    = on_bus && (ans_ack || ans_err);
  assign retry     = on_bus && ans_rty && !ans_ack && !ans_err;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (accept) phase_nx = PH_BUS;
      PH_BUS: begin
        if (finish)     phase_nx = PH_DONE;
        else if (retry) phase_nx = PH_GAP;
      end
      PH_GAP:  phase_nx = PH_BUS;
      PH_DONE: if (res_taken) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end

  // R4
  gap_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_GAP |=> phase == PH_BUS);
  // R8
  done_wait_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DONE && !res_taken |=> phase == PH_DONE);
endmodule

// File: rtl/wbc_result_reg.sv
module wbc_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_err,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else if (capture) begin
      valid <= 1'b1;
      data  <= cap_data;
      err   <= cap_err;
    end else if (take && valid) begin
      valid <= 1'b0;
    end
  end

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !take |=> valid && $stable(data) && $stable(err));
endmodule

// File: rtl/wbc_single_master.sv
module wbc_single_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int GRAN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_we,
  input  logic [DATA_W/GRAN_W-1:0] req_sel,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [DATA_W-1:0]        res_data,
  output logic                     res_err,
  output logic                     bus_cyc,
  output logic                     bus_stb,
  output logic [ADDR_W-1:0]        bus_adr,
  output logic [DATA_W-1:0]        bus_dat_w,
  output logic                     bus_we,
  output logic [DATA_W/GRAN_W-1:0] bus_sel,
  input  logic [DATA_W-1:0]        bus_dat_r,
  input  logic                     bus_ack,
  input  logic                     bus_err,
  input  logic                     bus_rty
);
  localparam int SEL_W = DATA_W / GRAN_W;

  logic accept, finish, on_bus;

  wbc_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ans_ack   (bus_ack),
    .ans_err   (bus_err),
    .ans_rty   (bus_rty),
    .res_taken (res_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .finish    (finish),
    .on_bus    (on_bus)
  );

  wbc_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_we    (req_we),
    .in_sel   (req_sel),
    .q_addr   (bus_adr),
    .q_wdata  (bus_dat_w),
    .q_we     (bus_we),
    .q_sel    (bus_sel)
  );

  wbc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .capture  (finish),
    .cap_data (bus_dat_r),
    .cap_err  (bus_err),
    .take     (res_ready),
    .valid    (res_valid),
    .data     (res_data),
    .err      (res_err)
  );

  // Classic mode: cyc and stb rise and fall together; both come from the phase register.
  assign bus_cyc = on_bus;
  assign bus_stb = on_bus;

  // R2
  field_stable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb && !bus_ack && !bus_err && !bus_rty |=>
      bus_stb && $stable(bus_adr) && $stable(bus_dat_w) && $stable(bus_we) && $stable(bus_sel));
  // R3
  close_after_ans_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb && (bus_ack || bus_err) |=> !bus_cyc && res_valid);
  // R4
  retry_replay_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb && bus_rty && !bus_ack && !bus_err |=> !bus_stb ##1 (bus_stb && $stable(bus_adr) && $stable(bus_dat_w)));
  // R5
  single_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && (bus_cyc || res_valid)));
endmodule

// File: tb/wbc_single_master_test.sv
module wbc_single_master_test;
  localparam int AW = 32, DW = 32, SW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_we = 1'b0;
  logic [SW-1:0] req_sel = '0;
  logic res_valid, res_ready = 1'b0, res_err;
  logic [DW-1:0] res_data;
  logic bus_cyc, bus_stb, bus_we;
  logic [AW-1:0] bus_adr;
  logic [DW-1:0] bus_dat_w, bus_dat_r = '0;
  logic [SW-1:0] bus_sel;
  logic bus_ack = 1'b0, bus_err = 1'b0, bus_rty = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wbc_single_master uut (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] wd;
    logic        we;
    logic [3:0]  sel;
    logic [31:0] rd;
    logic        err;
    logic [3:0]  lat;
    logic [3:0]  gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0002, 32'h0,         1'b0, 4'h1, 32'h0000_0008, 1'b0, 4'd0, 4'd0},
    '{32'h0000_0001, 32'h0,         1'b0, 4'h1, 32'h0000_0003, 1'b0, 4'd2, 4'd3},
    '{32'h0000_0003, 32'h0000_0005, 1'b1, 4'h0, 32'h0000_0000, 1'b0, 4'd1, 4'd0},
    '{32'hDEAD_0010, 32'h1234_5678, 1'b1, 4'hF, 32'hCAFE_F00D, 1'b0, 4'd5, 4'd7},
    '{32'h8000_0004, 32'h0,         1'b0, 4'h3, 32'h0000_0001, 1'b1, 4'd0, 4'd1},
    '{32'h0000_00FC, 32'hA5A5_A5A5, 1'b1, 4'hC, 32'h5555_AAAA, 1'b1, 4'd3, 4'd0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(logic [31:0] a, logic [31:0] wd, logic we, logic [3:0] sel);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_we = we; req_sel = sel;
    check("R1 ready before accept", req_ready, 1);
    step();
    req_valid = 1'b0;
  endtask

  task automatic check_fields(string req, logic [31:0] a, logic [31:0] wd, logic we, logic [3:0] sel);
    check(req, {bus_cyc, bus_stb}, 2'b11);
    check(req, bus_adr, a);
    check(req, bus_dat_w, wd);
    check(req, {bus_we, bus_sel}, {we, sel});
  endtask

  task automatic answer(logic [31:0] rd, logic ack, logic err, logic rty);
    bus_dat_r = rd; bus_ack = ack; bus_err = err; bus_rty = rty;
    step();
    bus_ack = 1'b0; bus_err = 1'b0; bus_rty = 1'b0; bus_dat_r = 32'hFFFF_FFFF;
  endtask

  task automatic consume();
    res_ready = 1'b1;
    step();
    res_ready = 1'b0;
    check("R8 released", {res_valid, req_ready}, 2'b01);
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    check("R9 reset state", {bus_cyc, bus_stb, res_valid, req_ready}, 4'b0001);
    rst = 1'b0;
    step();

    // table walk: R1 R2 R3 R6 R7
    for (int i = 0; i < 6; i++) begin
      repeat (VECS[i].gap) step();
      issue(VECS[i].a, VECS[i].wd, VECS[i].we, VECS[i].sel);
      check_fields("R1 fields", VECS[i].a, VECS[i].wd, VECS[i].we, VECS[i].sel);
      for (int k = 0; k < VECS[i].lat; k++) begin
        step();
        check_fields("R2 wait state", VECS[i].a, VECS[i].wd, VECS[i].we, VECS[i].sel);
      end
      answer(VECS[i].rd, !VECS[i].err, VECS[i].err, 1'b0);
      check("R3 bus closed", {bus_cyc, bus_stb}, 2'b00);
      check(VECS[i].err ? "R6 err result" : "R3 ack result",
            {res_valid, res_err, res_data}, {1'b1, VECS[i].err, VECS[i].rd});
      check("R7 not ready", req_ready, 0);
      consume();
    end

    // retry with a competing request offered throughout: R4 R5
    issue(32'h0000_0040, 32'h0BAD_BEEF, 1'b1, 4'h6);
    req_valid = 1'b1; req_addr = 32'h0000_0999; req_wdata = 32'h1; req_we = 1'b0; req_sel = 4'h1;
    answer(32'h1, 1'b0, 1'b0, 1'b1);
    check("R4 gap", {bus_cyc, bus_stb}, 2'b00);
    check("R5 refused during gap", req_ready, 0);
    step();
    check_fields("R4 replay", 32'h0000_0040, 32'h0BAD_BEEF, 1'b1, 4'h6);
    answer(32'h2, 1'b0, 1'b0, 1'b1);
    check("R4 second gap", bus_stb, 0);
    step();
    check_fields("R5 second replay", 32'h0000_0040, 32'h0BAD_BEEF, 1'b1, 4'h6);
    answer(32'h0000_7777, 1'b1, 1'b0, 1'b0);
    req_valid = 1'b0;
    check("R4 result after retry", {res_valid, res_err, res_data}, {2'b10, 32'h0000_7777});

    // R8 consumer stalls
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 held", {res_valid, res_err, res_data, bus_cyc, req_ready}, {2'b10, 32'h0000_7777, 2'b00});
    end
    consume();

    // ack and err together: R6
    issue(32'h10, 32'h0, 1'b0, 4'hF);
    answer(32'h0000_00EE, 1'b1, 1'b1, 1'b0);
    check("R6 err wins", {res_valid, res_err, res_data}, {2'b11, 32'h0000_00EE});
    consume();

    // rty together with ack: R10
    issue(32'h20, 32'h0, 1'b0, 4'hF);
    answer(32'h0000_0ABC, 1'b1, 1'b0, 1'b1);
    check("R10 completion not retry", {bus_stb, res_valid, res_err, res_data}, {3'b010, 32'h0000_0ABC});
    step();
    check("R10 no reissue", bus_stb, 0);
    consume();

    // reset mid-access: R9
    issue(32'h30, 32'h0, 1'b0, 4'hF);
    check("R9 open before reset", bus_stb, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R9 reset mid-access", {bus_cyc, bus_stb, res_valid, req_ready}, 4'b0001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule